// File: doc/BRIEF.md
# Audio Sample DMA with Serial Formatter

This block streams audio samples from memory to a serial audio output. Software writes a descriptor (a source address, a destination address and a buffer length in sample words) and a control word. Once enabled, the engine reads 32-bit sample words from memory in address order. It keeps them in a small FIFO and hands one word to the serial formatter at the start of each channel slot. After the last word of the buffer it reloads the source address and carries on without a gap. Because words leave at the fixed rate of the serial clock, the completion interrupt fires at a fixed interval: buffer length times 64 × SCK_DIV clock cycles.

The formatter sends a two-channel frame of 64 bit slots. The left channel occupies the first 32 slots with word-select low, and the right channel occupies the last 32 slots with word-select high. The sample sits in the low bits of each memory word. The control word selects 16-, 24- or 32-bit samples and left- or right-justified placement within the 32-bit slot. The serial clock runs at the system clock divided by 2 × SCK_DIV. Data changes after a falling edge and is stable at the rising edge.

The memory read port is a valid/ready request channel. A request holds its address and valid until ready is seen, and at most one read is in flight. The response channel has no ready: the engine only requests when a FIFO entry is free for the answer, so every response is always accepted. Status flags for completion, overrun and underrun are cleared by writing 1. The interrupt pin follows the completion flag.

Top module: `pcm_stream_dma`

## Requirements
- R1: After reset the status register (index 4) reads 0, and `irq`, `sck`, `ws` and `sdo` are low.
- R2: Register indices 1 (source), 2 (destination) and 3 (buffer length) read back the value last written.
- R3: Read requests go to source, source+4, … up to length words, then restart at source. Under back-pressure a request keeps `mem_req_valid` and `mem_req_addr` stable until `mem_req_ready`.
- R4: Control (index 0) holds enable in bit 0, right-justify in bit 1 and width code in bits 3:2 (0 = 16, 1 = 24, 2 or 3 = 32 bits). With bit 1 clear, slot b of a channel (b = 0 first) carries sample bit W-1-b for b < W, and 0 after that.
- R5: With bit 1 set, slots 32-W..31 carry sample bits W-1..0, and the earlier slots carry 0.
- R6: Words alternate left then right. `ws` is low for the left word and high for the right word. Each channel has 32 slots of 2 × SCK_DIV clock cycles.
- R7: The completion flag (status bit 0) is set once per length words sent. With no underrun, successive completions are exactly length × 64 × SCK_DIV cycles apart.
- R8: Status bit 0 stays set until 1 is written to it, and `irq` equals it.
- R9: A completion while status bit 0 is already set (and not being cleared in that cycle) sets overrun, status bit 1.
- R10: If the FIFO is empty when a channel starts, that channel is sent as all zeros and underrun, status bit 2, is set.
- R11: While enable is 0, no read is requested and `sck`, `ws` and `sdo` stay low. Enabling starts output only once the FIFO is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| irq | output | 1 | Buffer completion interrupt |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | ADDR_W | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| sck | output | 1 | Serial bit clock |
| ws | output | 1 | Word select, low for left channel |
| sdo | output | 1 | Serial data |

## Verification
A wrong fetch index or a missed address reload shows on the memory port at the very next request, and it shows on `sdo` one FIFO depth of words later as a wrong sample. A slot counter or divider fault moves `ws` or the sample's bit placement within one channel, which is 64 × SCK_DIV cycles. A misplaced buffer-end tag or completion logic shows as a wrong spacing between `irq` rises, visible at the second completion. Faults in the sticky or write-1-to-clear status bits show in the first status read after a completion.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int SLOT_BITS = 32;

  typedef enum logic [1:0] {
    WID_16  = 2'd0,
    WID_24  = 2'd1,
    WID_32  = 2'd2,
    WID_32B = 2'd3
  } wid_e;

  localparam logic [2:0] RI_CTRL = 3'd0;
  localparam logic [2:0] RI_SRC  = 3'd1;
  localparam logic [2:0] RI_DST  = 3'd2;
  localparam logic [2:0] RI_LEN  = 3'd3;
  localparam logic [2:0] RI_STAT = 3'd4;

  typedef struct packed {
    logic        last;
    logic [31:0] data;
  } fifo_ent_t;

  function automatic logic [5:0] wid_bits(wid_e w);
    case (w)
      WID_16:  return 6'd16;
      WID_24:  return 6'd24;
      default: return 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              done_evt,
  input  logic              underrun_evt,
  output logic              enable,
  output logic              rjust,
  output wid_e              wid,
  output logic [ADDR_W-1:0] src,
  output logic [LEN_W-1:0]  len,
  output logic              irq
);
  logic [ADDR_W-1:0] dst_q;
  logic pend_q, ovr_q, und_q;
  logic [2:0] clr;

  assign clr = (we && addr == RI_STAT) ? wdata[2:0] : 3'b000;
  assign irq = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= 1'b0;
      rjust  <= 1'b0;
      wid    <= WID_16;
      src    <= '0;
      dst_q  <= '0;
      len    <= '0;
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
      und_q  <= 1'b0;
    end else begin
      if (we) begin
        case (addr)
          RI_CTRL: begin
            enable <= wdata[0];
            rjust  <= wdata[1];
            wid    <= wid_e'(wdata[3:2]);
          end
          RI_SRC:  src   <= wdata[ADDR_W-1:0];
          RI_DST:  dst_q <= wdata[ADDR_W-1:0];
          RI_LEN:  len   <= wdata[LEN_W-1:0];
          default: ;
        endcase
      end
      if (done_evt)    pend_q <= 1'b1;
      else if (clr[0]) pend_q <= 1'b0;
      if (done_evt && pend_q && !clr[0]) ovr_q <= 1'b1;
      else if (clr[1])                   ovr_q <= 1'b0;
      if (underrun_evt) und_q <= 1'b1;
      else if (clr[2])  und_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      RI_CTRL: rdata = {28'd0, wid, rjust, enable};
      RI_SRC:  rdata = 32'(src);
      RI_DST:  rdata = 32'(dst_q);
      RI_LEN:  rdata = 32'(len);
      RI_STAT: rdata = {29'd0, und_q, ovr_q, pend_q};
      default: rdata = 32'd0;
    endcase
  end

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n) pend_q && !clr[0] |=> pend_q); // R8
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n) done_evt && pend_q && !clr[0] |=> ovr_q); // R9
  AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n) underrun_evt |=> und_q); // R10
endmodule

// File: rtl/sdma_fifo.sv
module sdma_fifo #(
  parameter int WIDTH = 33,
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CNT_W-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign dout = mem[rp];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push && !pop |-> count < CNT_W'(DEPTH)); // R3
  AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n) pop |-> count != '0); // R10
endmodule

// File: rtl/sdma_fetch.sv
module sdma_fetch
  import sdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ADDR_W-1:0] src,
  input  logic [LEN_W-1:0]  len,
  input  logic [CNT_W-1:0]  fifo_cnt,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_data,
  output logic              push,
  output fifo_ent_t         push_ent
);
  logic              busy_q, last_q, is_last;
  logic [LEN_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;

  assign is_last   = ({1'b0, idx_q} + 1'b1) >= {1'b0, len};
  assign req_valid = enable && !busy_q && (fifo_cnt < CNT_W'(DEPTH));
  assign req_addr  = addr_q;
  assign push      = rsp_valid && busy_q && enable;
  assign push_ent  = '{last: last_q, data: rsp_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      last_q <= 1'b0;
      idx_q  <= '0;
      addr_q <= '0;
    end else begin
      if (rsp_valid) busy_q <= 1'b0;
      if (!enable) begin
        idx_q  <= '0;
        addr_q <= src;
      end else if (req_valid && req_ready) begin
        busy_q <= 1'b1;
        last_q <= is_last;
        if (is_last) begin
          idx_q  <= '0;
          addr_q <= src;
        end else begin
          idx_q  <= idx_q + 1'b1;
          addr_q <= addr_q + ADDR_W'(4);
        end
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) req_valid && !req_ready |=> !enable || (req_valid && $stable(req_addr))); // R3
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n) !enable |-> !req_valid); // R11
endmodule

// File: rtl/sdma_serial.sv
module sdma_serial
  import sdma_pkg::*;
#(
  parameter int SCK_DIV = 2,
  parameter int DEPTH   = 4,
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             rjust,
  input  wid_e             wid,
  input  logic [CNT_W-1:0] fifo_cnt,
  input  fifo_ent_t        fifo_dout,
  output logic             pop,
  output logic             done_evt,
  output logic             underrun_evt,
  output logic             sck,
  output logic             ws,
  output logic             sdo
);
  localparam int DW = (SCK_DIV > 1) ? $clog2(SCK_DIV) : 1;

  logic          run_q, sck_q;
  logic [DW-1:0] div_q;
  logic [5:0]    slot_q;
  logic [31:0]   cur_q;
  logic          start, fall, load, empty, bit_v;
  logic [5:0]    wb, b, k;

  assign empty        = (fifo_cnt == '0);
  assign start        = enable && !run_q && (fifo_cnt == CNT_W'(DEPTH));
  assign fall         = run_q && sck_q && (div_q == DW'(SCK_DIV - 1));
  assign load         = start || (fall && (slot_q[4:0] == 5'd31));
  assign pop          = load && !empty;
  assign done_evt     = pop && fifo_dout.last;
  assign underrun_evt = load && empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      sck_q  <= 1'b0;
      div_q  <= '0;
      slot_q <= '0;
      cur_q  <= '0;
    end else if (!enable) begin
      run_q  <= 1'b0;
      sck_q  <= 1'b0;
      div_q  <= '0;
      slot_q <= '0;
      cur_q  <= '0;
    end else begin
      if (start) begin
        run_q  <= 1'b1;
        sck_q  <= 1'b0;
        div_q  <= '0;
        slot_q <= '0;
      end else if (run_q) begin
        if (div_q == DW'(SCK_DIV - 1)) begin
          div_q <= '0;
          sck_q <= ~sck_q;
          if (sck_q) slot_q <= slot_q + 1'b1;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
      if (load) cur_q <= empty ? 32'd0 : fifo_dout.data;
    end
  end

  always_comb begin
    wb    = wid_bits(wid);
    b     = {1'b0, slot_q[4:0]};
    k     = '0;
    bit_v = 1'b0;
    if (!rjust) begin
      if (b < wb) begin
        k     = wb - 6'd1 - b;
        bit_v = cur_q[k[4:0]];
      end
    end else if (b >= 6'd32 - wb) begin
      bit_v = cur_q[5'd31 - slot_q[4:0]];
    end
  end

  assign sck = sck_q;
  assign ws  = run_q & slot_q[5];
  assign sdo = run_q & bit_v;

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n) !enable |=> !sck && !ws && !sdo); // R11
  AST_UNDERRUN_ZERO: assert property (@(posedge clk) disable iff (!rst_n) enable && underrun_evt |=> !sdo); // R10
  AST_WS_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n) $rose(ws) |-> !sck_q && $past(sck_q)); // R6
  AST_START_FULL: assert property (@(posedge clk) disable iff (!rst_n) $rose(run_q) |-> $past(fifo_cnt) == CNT_W'(DEPTH)); // R11
endmodule

// File: rtl/pcm_stream_dma.sv
module pcm_stream_dma
  import sdma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int SCK_DIV    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              irq,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              sck,
  output logic              ws,
  output logic              sdo
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int ENT_W = $bits(fifo_ent_t);

  logic              enable, rjust, done_evt, underrun_evt, push, pop;
  wid_e              wid;
  logic [ADDR_W-1:0] src;
  logic [LEN_W-1:0]  len;
  logic [CNT_W-1:0]  fifo_cnt;
  fifo_ent_t         push_ent, fifo_dout;
  logic [ENT_W-1:0]  fifo_raw;

  assign fifo_dout = fifo_ent_t'(fifo_raw);

  sdma_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .done_evt(done_evt), .underrun_evt(underrun_evt),
    .enable(enable), .rjust(rjust), .wid(wid), .src(src), .len(len), .irq(irq)
  );

  sdma_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .enable(enable), .src(src), .len(len),
    .fifo_cnt(fifo_cnt), .req_valid(mem_req_valid), .req_ready(mem_req_ready),
    .req_addr(mem_req_addr), .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data),
    .push(push), .push_ent(push_ent)
  );

  sdma_fifo #(.WIDTH(ENT_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(!enable), .push(push), .din(push_ent),
    .pop(pop), .dout(fifo_raw), .count(fifo_cnt)
  );

  sdma_serial #(.SCK_DIV(SCK_DIV), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rjust(rjust), .wid(wid),
    .fifo_cnt(fifo_cnt), .fifo_dout(fifo_dout), .pop(pop), .done_evt(done_evt),
    .underrun_evt(underrun_evt), .sck(sck), .ws(ws), .sdo(sdo)
  );
endmodule

// File: tb/sim_pcm_stream_dma.sv
`timescale 1ns/1ps
module sim_pcm_stream_dma;
  localparam int DIV = 2;
  localparam int WORD_CYC = 64 * DIV;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = 3'd0;
  logic [31:0] cfg_wdata = 32'd0, cfg_rdata;
  logic irq, mem_req_valid, sck, ws, sdo;
  logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_req_addr, mem_rsp_data = 32'd0;

  pcm_stream_dma #(.SCK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq(irq), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .sck(sck), .ws(ws), .sdo(sdo)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  // stream settings used by the driver and the memory model
  logic [31:0] b_src = 0, b_len = 1;
  int b_w = 16;
  bit b_rj = 0;
  string cur_req = "R4";

  // memory model: back-pressure, one-cycle response, address check (R3)
  bit bp = 0, stall = 0, pend = 0;
  logic [31:0] pend_addr = 0;
  logic [7:0] lfsr = 8'hA7;
  int fetch_k = 0;
  always @(negedge clk) begin
    if (pend) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = memf(pend_addr);
      pend = 0;
    end else begin
      mem_rsp_valid = 1'b0;
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_req_ready = stall ? 1'b0 : (bp ? (lfsr[0] | lfsr[2]) : 1'b1);
    if (mem_req_valid && mem_req_ready) begin
      chk(mem_req_addr == b_src + 32'(4 * (fetch_k % int'(b_len))), "R3", mem_req_addr,
          b_src + 32'(4 * (fetch_k % int'(b_len))));
      fetch_k++;
      pend = 1;
      pend_addr = mem_req_addr;
    end
  end

  // scoreboard: driver pushes expected channel words, monitor pops and compares
  logic [31:0] exp_q[$];

  function automatic logic [31:0] fmt(input logic [31:0] d);
    logic [31:0] m;
    m = (b_w == 32) ? 32'hFFFF_FFFF : ((32'd1 << b_w) - 32'd1);
    return b_rj ? (d & m) : ((d & m) << (32 - b_w));
  endfunction

  task automatic drive_words(input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(fmt(memf(b_src + 32'(4 * (i % int'(b_len))))));
  endtask

  bit mon_on = 0, prev_sck = 0, chan = 0, ws_first = 0;
  int nbit = 0, t_first = 0;
  logic [31:0] cap = 0, e;
  always @(negedge clk) begin
    if (!mon_on) begin
      nbit = 0; chan = 0;
    end else if (sck && !prev_sck) begin
      if (nbit == 0) begin ws_first = ws; t_first = cyc; end
      cap = {cap[30:0], sdo};
      nbit++;
      if (nbit == 32) begin
        nbit = 0;
        if (exp_q.size() > 0) begin
          e = exp_q.pop_front();
          chk(cap == e, cur_req, cap, e);
          chk(ws_first == chan && ws == chan, "R6 ws", {31'd0, ws_first}, {31'd0, chan});
          chk(cyc - t_first == 31 * 2 * DIV, "R6 slot", 32'(cyc - t_first), 32'(31 * 2 * DIV));
        end
        chan = ~chan;
      end
    end
    prev_sck = sck;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_irq(output int t);
    @(negedge clk);
    while (!irq) @(negedge clk);
    t = cyc;
  endtask

  task automatic wait_drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic start_run(input logic [31:0] s, input logic [31:0] l, input int w, input bit rj, input int n);
    logic [1:0] code;
    b_src = s; b_len = l; b_w = w; b_rj = rj; fetch_k = 0;
    cur_req = rj ? "R5" : "R4";
    code = (w == 16) ? 2'd0 : ((w == 24) ? 2'd1 : 2'd2);
    wr(3'd1, s);
    wr(3'd3, l);
    exp_q.delete();
    drive_words(n);
    mon_on = 1;
    wr(3'd0, {28'd0, code, rj, 1'b1});
  endtask

  task automatic stop_run();
    wr(3'd0, 32'd0);
    mon_on = 0;
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int t0, t1, t2, nreq;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq == 0, "R1 irq", {31'd0, irq}, 0);
    chk({sck, ws, sdo} == 3'b000, "R1 pins", {29'd0, sck, ws, sdo}, 0);
    chk(mem_req_valid == 0, "R11 no req", {31'd0, mem_req_valid}, 0);
    rd(3'd4, v); chk(v == 0, "R1 status", v, 0);

    wr(3'd1, 32'h0000_1000); wr(3'd2, 32'h0000_8000); wr(3'd3, 32'd4);
    rd(3'd1, v); chk(v == 32'h1000, "R2 src", v, 32'h1000);
    rd(3'd2, v); chk(v == 32'h8000, "R2 dst", v, 32'h8000);
    rd(3'd3, v); chk(v == 32'd4, "R2 len", v, 32'd4);

    // run A: left-justified 16-bit, interval check
    start_run(32'h1000, 4, 16, 0, 12);
    wait_irq(t0);
    repeat (20) @(negedge clk);
    chk(irq == 1, "R8 sticky", {31'd0, irq}, 1);
    wr(3'd4, 32'd1);
    @(negedge clk); chk(irq == 0, "R8 clear", {31'd0, irq}, 0);
    wait_irq(t1); wr(3'd4, 32'd1);
    wait_irq(t2); wr(3'd4, 32'd1);
    chk(t1 - t0 == 4 * WORD_CYC, "R7 interval", 32'(t1 - t0), 32'(4 * WORD_CYC));
    chk(t2 - t1 == 4 * WORD_CYC, "R7 interval", 32'(t2 - t1), 32'(4 * WORD_CYC));
    wait_drain();
    stop_run();

    // disabled: pins idle, no requests
    nreq = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (mem_req_valid || sck || ws || sdo) nreq++;
    end
    chk(nreq == 0, "R11 idle", 32'(nreq), 0);

    // run B: right-justified 24-bit under back-pressure
    bp = 1;
    start_run(32'h2040, 4, 24, 1, 8);
    wait_irq(t0); wr(3'd4, 32'd1);
    wait_irq(t1); wr(3'd4, 32'd1);
    chk(t1 - t0 == 4 * WORD_CYC, "R7 interval bp", 32'(t1 - t0), 32'(4 * WORD_CYC));
    wait_drain();
    stop_run();
    bp = 0;

    // run C: left-justified 32-bit, length 3, completions left uncleared
    wr(3'd4, 32'd7);
    start_run(32'h3000, 3, 32, 0, 9);
    wait_drain();
    rd(3'd4, v); chk(v == 32'd3, "R9 overrun", v, 32'd3);
    wr(3'd4, 32'd3);
    rd(3'd4, v); chk(v == 32'd0, "R8 w1c", v, 32'd0);
    chk(irq == 0, "R8 irq low", {31'd0, irq}, 0);
    stop_run();

    // run D: memory stall drains the FIFO
    wr(3'd4, 32'd7);
    start_run(32'h4000, 8, 16, 0, 0);
    mon_on = 0;
    repeat (200) @(negedge clk);
    stall = 1;
    repeat (1200) @(negedge clk);
    rd(3'd4, v); chk(v[2] == 1'b1, "R10 flag", v, 32'd4);
    nreq = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sdo) nreq++;
    end
    chk(nreq == 0, "R10 zeros", 32'(nreq), 0);
    stall = 0;
    stop_run();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule